// File: doc/BRIEF.md
# Deskew Loop Local Controller

This block is the digital half of a per-region clock deskew loop. At a fixed interval it opens a comparison window. On the closing edge of that window it captures the lead/lag bit from an external phase comparator. The comparator weighs a region's feedback clock against a shared reference clock. The controller keeps a short history of these decisions and votes over it. When the vote is clear, it asks an external delay register for one step more or one step less delay.

Calibration starts with a start pulse after reset. It ends in one of two ways. The normal end comes when the history shows the loop toggling between early and late on every sample, which means the edges sit within one delay step. In that case the controller adds one final bias step so that the feedback clock ends ahead of the reference, then raises done. The other end is a timeout on the number of comparison windows, which raises done together with an error flag. After either end the delay setting stays frozen until the next reset.

Top module: `phase_trim_ctrl`

## Requirements
- R1: While reset is high, and afterwards until start is seen, cmp_en_o, step_dec_o, step_inc_o, busy_o, done_o and timeout_err_o are all 0.
- R2: A start pulse in the idle state raises busy_o in the next cycle. cmp_en_o then pulses high for one cycle every WINDOW (16) cycles, and the first pulse falls in the 16th cycle after the start edge. A start pulse during calibration does not shift this cadence.
- R3: fb_late_i is captured only on the clock edge that ends a cmp_en_o cycle. Its value in any other cycle has no effect.
- R4: fb_late_i = 1 means the feedback clock is late. When the six newest captured samples hold at least MAJ (6) late values, step_dec_o pulses for one cycle. That cycle is two cycles after the capturing edge. The pulse repeats on every window for as long as the condition holds.
- R5: When the six newest samples hold at least MAJ early (0) values, step_inc_o pulses for one cycle with the same timing as R4.
- R6: No step is requested before six samples have been captured since start, or while the vote reaches neither threshold.
- R7: When six captured samples alternate strictly (each differs from the one before it), calibration ends. In the same cycle that a step would appear, done_o rises and busy_o falls, and no further comparisons or steps follow.
- R8: At the end described in R7, step_dec_o pulses once together with the rising done_o if the newest sample was late. If the newest sample was early, no step is issued.
- R9: If the TIMEOUT_WIN-th (64th) sample does not produce the pattern of R7, done_o and timeout_err_o rise together in the cycle a step would appear, and no step is issued for that sample.
- R10: Once done_o is high, it stays high until reset, and start pulses are ignored.
- R11: step_inc_o and step_dec_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin calibration (one-cycle pulse) |
| fb_late_i | input | 1 | Comparator result, 1 = feedback late |
| cmp_en_o | output | 1 | Comparison window enable, high in the capture cycle |
| step_dec_o | output | 1 | Request one step less delay |
| step_inc_o | output | 1 | Request one step more delay |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished, held until reset |
| timeout_err_o | output | 1 | Calibration ended by the window limit |

## Verification
The hardest condition to reach from the ports is the settled state. It has to arrive only after earlier steps have already been taken, which requires the full six-sample history to alternate exactly while older unanimous samples drop out of the vote one by one. The stimulus builds this one window at a time from a vector table, in a single run: a late streak, a mixed stretch, an early streak, and then an alternating tail whose last sample decides the bias. The timeout needs 64 windows of a repeating late-late-early pattern that never satisfies the vote or the settle test. In every window the comparator input carries the inverse value outside the capture cycle, which shows that only the enabled edge counts.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} ctl_state_t;
  typedef enum logic [1:0] {VD_HOLD, VD_LESS, VD_MORE, VD_SETTLED} vote_t;
endpackage

// File: rtl/ptc_cadence.sv
module ptc_cadence #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam bit POW2 = (WINDOW == (1 << CW));

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  generate
    if (POW2) begin : g_wrap
      assign cnt_nxt = cnt_q + 1'b1;
    end else begin : g_cmp
      assign cnt_nxt = (cnt_q == CW'(WINDOW - 1)) ? '0 : cnt_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      tick_o <= (cnt_q == CW'(WINDOW - 2));
    end
  end

  p_tick_single_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  p_tick_needs_run_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(run_i));
endmodule

// File: rtl/ptc_history.sv
module ptc_history #(
  parameter int TAPS = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [TAPS-1:0] hist_o,
  output logic            full_o
);
  localparam int VW = $clog2(TAPS + 1);

  logic [VW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      hist_o <= '0;
      fill_q <= '0;
    end else if (shift_i) begin
      hist_o <= {hist_o[TAPS-2:0], bit_i};
      if (fill_q != VW'(TAPS)) fill_q <= fill_q + 1'b1;
    end
  end

  assign full_o = (fill_q == VW'(TAPS));

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fill_q <= VW'(TAPS));
  p_fill_step_r6: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !clr_i) |=> $stable(fill_q));
endmodule

// File: rtl/ptc_vote.sv
module ptc_vote import ptc_pkg::*; #(
  parameter int TAPS = 6,
  parameter int MAJ  = 6
) (
  input  logic [TAPS-1:0] hist_i,
  input  logic            full_i,
  output vote_t           vote_o
);
  logic [TAPS-2:0] flip;
  int unsigned     n_late;
  int unsigned     n_early;

  genvar gi;
  generate
    for (gi = 0; gi < TAPS - 1; gi++) begin : g_flip
      assign flip[gi] = hist_i[gi] ^ hist_i[gi+1];
    end
  endgenerate

  always_comb begin
    n_late  = $countones(hist_i);
    n_early = TAPS - n_late;
    vote_o  = VD_HOLD;
    if (full_i) begin
      if (&flip)                vote_o = VD_SETTLED;
      else if (n_late  >= MAJ)  vote_o = VD_LESS;
      else if (n_early >= MAJ)  vote_o = VD_MORE;
    end
  end
endmodule

// File: rtl/phase_trim_ctrl.sv
module phase_trim_ctrl import ptc_pkg::*; #(
  parameter int WINDOW      = 16,
  parameter int TAPS        = 6,
  parameter int MAJ         = 6,
  parameter int TIMEOUT_WIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic fb_late_i,
  output logic cmp_en_o,
  output logic step_dec_o,
  output logic step_inc_o,
  output logic busy_o,
  output logic done_o,
  output logic timeout_err_o
);
  localparam int WW = $clog2(TIMEOUT_WIN + 1);

  ctl_state_t      state_q;
  logic            run;
  logic            tick;
  logic            eval_q;
  logic            clr;
  logic [TAPS-1:0] hist;
  logic            full;
  vote_t           vote;
  logic [WW-1:0]   nwin_q;

  assign run = (state_q == ST_RUN);
  assign clr = (state_q == ST_IDLE) && start_i;

  ptc_cadence #(.WINDOW(WINDOW)) u_cad (
    .clk(clk), .rst(rst), .run_i(run), .tick_o(tick)
  );

  ptc_history #(.TAPS(TAPS)) u_hist (
    .clk(clk), .rst(rst), .clr_i(clr), .shift_i(tick),
    .bit_i(fb_late_i), .hist_o(hist), .full_o(full)
  );

  ptc_vote #(.TAPS(TAPS), .MAJ(MAJ)) u_vote (
    .hist_i(hist), .full_i(full), .vote_o(vote)
  );

  assign cmp_en_o = tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      eval_q        <= 1'b0;
      nwin_q        <= '0;
      step_dec_o    <= 1'b0;
      step_inc_o    <= 1'b0;
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      step_dec_o <= 1'b0;
      step_inc_o <= 1'b0;
      eval_q     <= tick && run;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_RUN;
            busy_o  <= 1'b1;
            nwin_q  <= '0;
          end
        end
        ST_RUN: begin
          if (tick) nwin_q <= nwin_q + 1'b1;
          if (eval_q) begin
            if (vote == VD_SETTLED) begin
              state_q    <= ST_DONE;
              busy_o     <= 1'b0;
              done_o     <= 1'b1;
              step_dec_o <= hist[0];
            end else if (nwin_q == WW'(TIMEOUT_WIN)) begin
              state_q       <= ST_DONE;
              busy_o        <= 1'b0;
              done_o        <= 1'b1;
              timeout_err_o <= 1'b1;
            end else if (vote == VD_LESS) begin
              step_dec_o <= 1'b1;
            end else if (vote == VD_MORE) begin
              step_inc_o <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  p_steps_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(step_inc_o && step_dec_o));
  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));
  p_err_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    timeout_err_o |-> done_o);
  p_inc_needs_busy_r5: assert property (@(posedge clk) disable iff (rst)
    step_inc_o |-> $past(busy_o));
  p_dec_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    step_dec_o |=> !step_dec_o);
  p_window_busy_r2: assert property (@(posedge clk) disable iff (rst)
    cmp_en_o |-> busy_o);
endmodule

// File: tb/phase_trim_ctrl_tb_top.sv
`timescale 1ns/1ps
module phase_trim_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic fb_late = 1'b0;
  logic cmp_en, step_dec, step_inc, busy, done, terr;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  phase_trim_ctrl dut_i (
    .clk(clk), .rst(rst), .start_i(start), .fb_late_i(fb_late),
    .cmp_en_o(cmp_en), .step_dec_o(step_dec), .step_inc_o(step_inc),
    .busy_o(busy), .done_o(done), .timeout_err_o(terr)
  );

  // {late, exp_dec, exp_inc, exp_done} per comparison window, one run
  localparam logic [3:0] VEC [0:17] = '{
    4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 4'b1100,
    4'b1100, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000,
    4'b0010, 4'b1000, 4'b0000, 4'b1000, 4'b0000, 4'b1101
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Drives the inverse value outside the capture cycle (R3 noise)
  task automatic run_window(input logic late, input logic e_dec, input logic e_inc,
                            input logic e_done, input logic e_err, input string req);
    int guard = 0;
    fb_late = ~late;
    while (cmp_en !== 1'b1 && guard < 100) begin
      @(negedge clk); guard++;
    end
    chk({req, " window seen"}, int'(cmp_en), 1);
    fb_late = late;
    @(negedge clk); fb_late = ~late;
    @(negedge clk);
    chk({req, " step_dec"}, int'(step_dec), int'(e_dec));
    chk({req, " step_inc"}, int'(step_inc), int'(e_inc));
    chk({req, " done"}, int'(done), int'(e_done));
    chk({req, " busy"}, int'(busy), int'(!e_done));
    chk({req, " timeout_err"}, int'(terr), int'(e_err));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int seen;
    string req;
    // R1 reset and idle state
    do_reset();
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      seen += int'(cmp_en | step_dec | step_inc | busy | done | terr);
    end
    chk("R1 idle outputs", seen, 0);

    // R2 cadence
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 1;
    chk("R2 busy after start", int'(busy), 1);
    while (!cmp_en && n < 100) begin @(negedge clk); n++; end
    chk("R2 first window cycle", n, 16);
    n = 0;
    do begin
      @(negedge clk); n++;
      start = (n == 5);
    end while (!cmp_en && n < 100);
    chk("R2 period with start mid-run", n, 16);
    chk("R2 still busy", int'(busy), 1);

    // Table run: R4 R5 R6 R7 R8 R3
    do_reset();
    pulse_start();
    for (int i = 0; i < 18; i++) begin
      if (VEC[i][0])      req = "R7 R8 settle";
      else if (VEC[i][2]) req = "R4 dec";
      else if (VEC[i][1]) req = "R5 inc";
      else                req = "R6 hold";
      run_window(VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0, req);
    end

    // R10 start ignored after done
    pulse_start();
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      seen += int'(cmp_en | step_dec | step_inc | busy);
    end
    chk("R10 no activity after done", seen, 0);
    chk("R10 done held", int'(done), 1);
    do_reset();
    @(negedge clk);
    chk("R1 done cleared by reset", int'(done), 0);

    // R8 settle with newest sample early: no bias step
    pulse_start();
    for (int i = 0; i < 6; i++)
      run_window(((i % 2) == 0), 1'b0, 1'b0, (i == 5), 1'b0, "R8 early bias");

    // R9 timeout
    do_reset();
    pulse_start();
    for (int i = 0; i < 64; i++)
      run_window(((i % 3) != 2), 1'b0, 1'b0, (i == 63), (i == 63), "R9 timeout");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule